// File: doc/BRIEF.md
# Register-Mapped Integer Divide and Square-Root Unit

This block is a small arithmetic coprocessor that sits on a simple register bus. Software loads operands into registers, starts an operation and reads back one 32-bit result. It performs 32-bit integer division, signed or unsigned, and returns either the quotient or the remainder. It also computes the integer square root of a 32-bit unsigned value, which gives a 16-bit result. Both operations run on iterative datapaths that produce one result bit per cycle. A combined status field shows whether the unit is busy and which kind of operation ran last.

A division starts in one of two ways. By default, writing the divisor register starts it at once. When the manual-start bit is set, writing the divisor only stores it, and the division starts when the control register is written with both the manual-start and go bits set. Writing the radicand register always starts a square root. A zero divisor raises a sticky flag. If divide-by-zero errors are enabled, a later result read ends with a bus error instead of data. A result read issued while the unit is busy is held off through a ready signal until the result is available.

Register map (word address on `bus_addr`): 0 control/status, 1 dividend, 2 divisor, 3 radicand, 4 result (read-only). Reads of any other address return zero.

Top module: `arith_cop`

## Requirements
- R1: After reset the control/status register reads 0 and the result register reads 0. When no read is in progress, `bus_ready` is 1 and `bus_err` is 0.
- R2: With control bit 0 (unsigned) set, a division returns the unsigned quotient if control bit 1 is 0 and the unsigned remainder if it is 1. The choice is made when the operation completes.
- R3: With control bit 0 clear, division is signed. The quotient truncates toward zero and the remainder takes the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: With control bit 3 (manual start) clear, writing the divisor register (address 2) starts a division. Status field bits [10:8] of the control register read 0x6 for exactly 32 consecutive cycles and then 0x2.
- R5: With control bit 3 set, a divisor write does not start a division. A control write with bit 4 (go) and bit 3 both set starts one using the stored operands and the newly written configuration. A go write with bit 3 clear starts nothing. Bit 4 always reads back as 0.
- R6: Writing the radicand register (address 3) starts a square root. The status field reads 0x5 for exactly 16 cycles and then 0x1. The result holds floor(sqrt(radicand)), zero-extended.
- R7: A division with a zero divisor completes in the cycle of its start without going busy. It sets the divide-by-zero flag (control bit 5) and writes the result as 0xFFFFFFFF (quotient selected) or the dividend (remainder selected). The next operation to start clears the flag.
- R8: A result read while the divide-by-zero flag and control bit 2 (error enable) are both set returns `bus_err`=1 with read data 0. Otherwise the result is returned with `bus_err`=0.
- R9: A result read issued while busy holds `bus_ready` at 0 until the operation finishes. The read then completes with the new result in the first idle cycle.
- R10: Every register write made while busy is ignored, including one that lands on the completing edge. The same write is accepted once the unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, held until `bus_ready` |
| bus_rdata | output | 32 | Read data, valid when `bus_rd` and `bus_ready` are high |
| bus_ready | output | 1 | Low while a result read must wait |
| bus_err | output | 1 | Error response for the current read |

## Verification
Two functions can fall in the same cycle.

- **Read against completion.** A pending result read can meet the completing edge of a division. The bench issues a result read directly after the start and holds it across all 32 stall cycles. It expects `bus_ready` to rise in the first idle cycle, carrying the new quotient rather than the previous result.
- **Write against completion.** A register write can also land on that completing edge. The bench times a dividend write to reach exactly the 32nd busy edge. It then reads the dividend back, expecting the old value, and repeats the write one cycle later, expecting it to take.

A write made on the start edge's successor, to the control register, is judged by reading back the unchanged configuration.

// File: rtl/arith_cop_pkg.sv
package arith_cop_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_NUMER  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DENOM  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RADIC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RESULT = 3'd4;

    localparam int B_MAN = 3;
    localparam int B_GO  = 4;

    // Field order matches control bits [3:0].
    typedef struct packed {
        logic manual_start;
        logic dz_err_en;
        logic sel_rem;
        logic use_unsigned;
    } cfg_t;

    // Encoded so that {div, sqrt} are the two low status bits.
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SQRT = 2'b01,
        OP_DIV  = 2'b10
    } op_e;

endpackage

// File: rtl/arith_cop_div.sv
module arith_cop_div
    import arith_cop_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] numer,
    input  logic [W-1:0] denom,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W);

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
        return (sgn && v[W-1]) ? (~v + 1'b1) : v;
    endfunction

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q, quo_q, den_q;
    logic          negq_q, negr_q;

    logic [W:0]    trial, diff;
    logic          ge;
    logic [W-1:0]  nrem, nquo;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, den_q};
        ge    = ~diff[W];
        nrem  = ge ? diff[W-1:0] : trial[W-1:0];
        nquo  = {quo_q[W-2:0], ge};
    end

    assign done = busy_q && (cnt_q == CW'(W - 1));
    assign quo  = negq_q ? (~nquo + 1'b1) : nquo;
    assign rem  = negr_q ? (~nrem + 1'b1) : nrem;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= magnitude(numer, is_signed);
            den_q  <= magnitude(denom, is_signed);
            negq_q <= is_signed && (numer[W-1] ^ denom[W-1]);
            negr_q <= is_signed && numer[W-1];
        end else if (busy_q) begin
            rem_q <= nrem;
            quo_q <= nquo;
            cnt_q <= cnt_q + 1'b1;
            if (done) busy_q <= 1'b0;
        end
    end

    // R7
    div_nonzero_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (denom != '0));

    // R10
    div_idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/arith_cop_sqrt.sv
module arith_cop_sqrt
    import arith_cop_pkg::*;
#(
    parameter int RW = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [RW-1:0]   radicand,
    output logic            done,
    output logic [RW/2-1:0] root
);
    localparam int OW = RW / 2;
    localparam int MW = OW + 3;
    localparam int CW = $clog2(OW);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] rad_q;
    logic [MW-1:0] rem_q;
    logic [OW-1:0] root_q;

    logic [MW-1:0] acc, trial, nrem;
    logic          ge;
    logic [OW-1:0] nroot;

    always_comb begin
        acc   = {rem_q[MW-3:0], rad_q[RW-1:RW-2]};
        trial = {1'b0, root_q, 2'b01};
        ge    = (acc >= trial);
        nrem  = ge ? (acc - trial) : acc;
        nroot = {root_q[OW-2:0], ge};
    end

    assign done = busy_q && (cnt_q == CW'(OW - 1));
    assign root = nroot;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            rad_q  <= radicand;
            rem_q  <= '0;
            root_q <= '0;
        end else if (busy_q) begin
            rad_q  <= {rad_q[RW-3:0], 2'b00};
            rem_q  <= nrem;
            root_q <= nroot;
            cnt_q  <= cnt_q + 1'b1;
            if (done) busy_q <= 1'b0;
        end
    end

    // R10
    sqrt_idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/arith_cop.sv
module arith_cop
    import arith_cop_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ready,
    output logic          bus_err
);
    localparam int ROOT_W = DW / 2;
    localparam int CYC_W  = $clog2(DW) + 1;

    cfg_t          cfg_q;
    op_e           op_q;
    logic          dz_q, busy_q;
    logic [DW-1:0] numer_q, denom_q, radic_q, result_q;

    logic          wr_ok, div_fast, div_go, div_req, div_zero, div_start, sq_start;
    logic [DW-1:0] div_den;
    cfg_t          div_cfg;
    logic          div_done, sq_done;
    logic [DW-1:0] div_quo, div_rem;
    logic [ROOT_W-1:0] sq_root;

    always_comb begin
        wr_ok     = bus_wr && !busy_q;
        div_fast  = wr_ok && (bus_addr == A_DENOM) && !cfg_q.manual_start;
        div_go    = wr_ok && (bus_addr == A_CTRL) && bus_wdata[B_GO] && bus_wdata[B_MAN];
        div_req   = div_fast || div_go;
        div_den   = div_fast ? bus_wdata : denom_q;
        div_cfg   = div_go ? cfg_t'(bus_wdata[3:0]) : cfg_q;
        div_zero  = div_req && (div_den == '0);
        div_start = div_req && !div_zero;
        sq_start  = wr_ok && (bus_addr == A_RADIC);
    end

    arith_cop_div #(.W(DW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (div_start),
        .is_signed (!div_cfg.use_unsigned),
        .numer     (numer_q),
        .denom     (div_den),
        .done      (div_done),
        .quo       (div_quo),
        .rem       (div_rem)
    );

    arith_cop_sqrt #(.RW(DW)) u_sqrt (
        .clk      (clk),
        .rst      (rst),
        .start    (sq_start),
        .radicand (bus_wdata),
        .done     (sq_done),
        .root     (sq_root)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            op_q     <= OP_NONE;
            dz_q     <= 1'b0;
            busy_q   <= 1'b0;
            numer_q  <= '0;
            denom_q  <= '0;
            radic_q  <= '0;
            result_q <= '0;
        end else begin
            if (wr_ok) begin
                case (bus_addr)
                    A_CTRL:  cfg_q   <= cfg_t'(bus_wdata[3:0]);
                    A_NUMER: numer_q <= bus_wdata;
                    A_DENOM: denom_q <= bus_wdata;
                    A_RADIC: radic_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (div_req || sq_start) begin
                dz_q   <= div_zero;
                op_q   <= sq_start ? OP_SQRT : OP_DIV;
                busy_q <= div_start || sq_start;
            end
            if (div_zero)
                result_q <= div_cfg.sel_rem ? numer_q : '1;
            if (div_done) begin
                result_q <= cfg_q.sel_rem ? div_rem : div_quo;
                busy_q   <= 1'b0;
            end
            if (sq_done) begin
                result_q <= DW'(sq_root);
                busy_q   <= 1'b0;
            end
        end
    end

    logic [2:0] status;
    logic       rd_res, stall;

    always_comb begin
        status    = {busy_q, op_q};
        rd_res    = bus_rd && (bus_addr == A_RESULT);
        stall     = rd_res && busy_q;
        bus_ready = !stall;
        bus_err   = rd_res && !busy_q && dz_q && cfg_q.dz_err_en;
        bus_rdata = '0;
        if (bus_rd && !stall && !bus_err) begin
            case (bus_addr)
                A_CTRL:   bus_rdata = DW'({status, 2'b00, dz_q, 1'b0, cfg_q});
                A_NUMER:  bus_rdata = numer_q;
                A_DENOM:  bus_rdata = denom_q;
                A_RADIC:  bus_rdata = radic_q;
                A_RESULT: bus_rdata = result_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Checking aids: busy-cycle counter and square bounds.
    logic [CYC_W-1:0]  cyc_q;
    logic [2*DW-1:0]   r_ext, sq_lo, sq_hi;

    always_ff @(posedge clk) begin
        if (rst)                        cyc_q <= '0;
        else if (div_start || sq_start) cyc_q <= '0;
        else if (busy_q)                cyc_q <= cyc_q + 1'b1;
    end

    always_comb begin
        r_ext = (2*DW)'(sq_root);
        sq_lo = r_ext * r_ext;
        sq_hi = (r_ext + 1'b1) * (r_ext + 1'b1);
    end

    // R4
    div_len_chk: assert property (@(posedge clk) disable iff (rst)
        div_done |-> (cyc_q == CYC_W'(DW - 1)));

    // R6
    sqrt_len_chk: assert property (@(posedge clk) disable iff (rst)
        sq_done |-> (cyc_q == CYC_W'(ROOT_W - 1)));

    // R2
    div_identity_chk: assert property (@(posedge clk) disable iff (rst)
        div_done |-> (DW'(div_quo * denom_q + div_rem) == numer_q));

    // R6
    sqrt_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        sq_done |-> ((sq_lo <= (2*DW)'(radic_q)) && (sq_hi > (2*DW)'(radic_q))));

    // R10
    operands_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> ($stable(numer_q) && $stable(denom_q)
                                       && $stable(radic_q) && $stable(cfg_q)));

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_ready && (op_q == OP_DIV)));

endmodule

// File: tb/arith_cop_bench.sv
module arith_cop_bench;
    import arith_cop_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_ready, bus_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    arith_cop u_arith_cop (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err)
    );

    typedef struct packed {
        logic        uns;
        logic [31:0] n;
        logic [31:0] d;
        logic [31:0] q;
        logic [31:0] r;
    } dv_t;

    localparam dv_t DV [9] = '{
        '{1'b1, 32'd100,      32'd7,        32'd14,       32'd2},
        '{1'b1, 32'hFFFFFFFF, 32'h10,       32'h0FFFFFFF, 32'hF},
        '{1'b1, 32'd5,        32'd9,        32'd0,        32'd5},
        '{1'b1, 32'h80000000, 32'hFFFFFFFF, 32'd0,        32'h80000000},
        '{1'b0, 32'hFFFFFFF9, 32'd2,        32'hFFFFFFFD, 32'hFFFFFFFF},
        '{1'b0, 32'd7,        32'hFFFFFFFE, 32'hFFFFFFFD, 32'd1},
        '{1'b0, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'd3,        32'hFFFFFFFF},
        '{1'b0, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'd0},
        '{1'b0, 32'h80000000, 32'd2,        32'hC0000000, 32'd0}
    };

    localparam logic [31:0] SQ_IN  [8] = '{32'd0, 32'd1, 32'd15, 32'd16,
        32'd1000000, 32'hFFFE0001, 32'hFFFE0000, 32'hFFFFFFFF};
    localparam logic [31:0] SQ_OUT [8] = '{32'd0, 32'd1, 32'd3, 32'd4,
        32'd1000, 32'hFFFF, 32'hFFFE, 32'hFFFF};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic e,
                      output int stalls);
        bus_addr = a; bus_rd = 1'b1; stalls = 0;
        #1;
        while (!bus_ready && stalls < 200) begin
            @(negedge clk); #1; stalls++;
        end
        d = bus_rdata; e = bus_err;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdv(input logic [2:0] a, output logic [31:0] d);
        logic e; int s;
        rd(a, d, e, s);
    endtask

    // Returns the number of samples seen busy with the given status code.
    task automatic count_busy(input logic [2:0] code, output int n);
        logic [31:0] v;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            rdv(A_CTRL, v);
            if (!v[10]) break;
            if (v[10:8] == code) n++;
        end
    endtask

    task automatic wait_idle();
        int n;
        count_busy(3'b111, n);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic e;
        int s, n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rdv(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
        rd(A_RESULT, v, e, s);
        chk("R1 result", v, 32'h0);
        chk("R1 err", {31'b0, e}, 32'd0);
        #1; chk("R1 ready idle", {31'b0, bus_ready}, 32'd1);

        // R2 / R3 vector table
        for (int i = 0; i < 9; i++) begin
            for (int sel = 0; sel < 2; sel++) begin
                wr(A_CTRL, {30'b0, sel[0], DV[i].uns});
                wr(A_NUMER, DV[i].n);
                wr(A_DENOM, DV[i].d);
                wait_idle();
                rdv(A_RESULT, v);
                if (DV[i].uns) chk("R2 div", v, sel[0] ? DV[i].r : DV[i].q);
                else           chk("R3 div", v, sel[0] ? DV[i].r : DV[i].q);
            end
        end

        // R4 fast start, busy length and status codes
        wr(A_CTRL, 32'h1);
        wr(A_NUMER, 32'd50);
        wr(A_DENOM, 32'd5);
        count_busy(3'b110, n);
        chk("R4 busy cycles", n, 32'd32);
        rdv(A_CTRL, v);   chk("R4 idle status", v, 32'h201);
        rdv(A_RESULT, v); chk("R4 result", v, 32'd10);

        // R5 manual start
        wr(A_CTRL, 32'h9);
        wr(A_NUMER, 32'd81);
        wr(A_DENOM, 32'd9);
        rdv(A_CTRL, v);   chk("R5 no launch", v, 32'h209);
        rdv(A_RESULT, v); chk("R5 result kept", v, 32'd10);
        wr(A_CTRL, 32'h19);
        rdv(A_CTRL, v);   chk("R5 go busy", v, 32'h609);
        wait_idle();
        rdv(A_RESULT, v); chk("R5 go result", v, 32'd9);
        wr(A_CTRL, 32'h11);
        rdv(A_CTRL, v);   chk("R5 go without manual", v, 32'h201);

        // R6 square root
        wr(A_CTRL, 32'h0);
        for (int i = 0; i < 8; i++) begin
            wr(A_RADIC, SQ_IN[i]);
            count_busy(3'b101, n);
            chk("R6 busy cycles", n, 32'd16);
            rdv(A_RESULT, v); chk("R6 root", v, SQ_OUT[i]);
        end
        rdv(A_CTRL, v);   chk("R6 idle status", v, 32'h100);

        // R7 zero divisor
        wr(A_CTRL, 32'h1);
        wr(A_NUMER, 32'h1234);
        wr(A_DENOM, 32'h0);
        rdv(A_CTRL, v);   chk("R7 flag no busy", v, 32'h221);
        rdv(A_RESULT, v); chk("R7 quotient ones", v, 32'hFFFFFFFF);
        wr(A_CTRL, 32'h3);
        wr(A_DENOM, 32'h0);
        rdv(A_RESULT, v); chk("R7 remainder dividend", v, 32'h1234);
        wr(A_RADIC, 32'd4);
        rdv(A_CTRL, v);   chk("R7 flag cleared", v, 32'h503);
        wait_idle();

        // R8 error response
        wr(A_CTRL, 32'h5);
        wr(A_NUMER, 32'd7);
        wr(A_DENOM, 32'd0);
        rd(A_RESULT, v, e, s);
        chk("R8 err set", {31'b0, e}, 32'd1);
        chk("R8 err data", v, 32'd0);
        wr(A_CTRL, 32'h1);
        rd(A_RESULT, v, e, s);
        chk("R8 err off flag", {31'b0, e}, 32'd0);
        chk("R8 err off data", v, 32'hFFFFFFFF);
        wr(A_CTRL, 32'h5);
        wr(A_DENOM, 32'd7);
        wait_idle();
        rd(A_RESULT, v, e, s);
        chk("R8 enabled no flag", {31'b0, e}, 32'd0);
        chk("R8 enabled data", v, 32'd1);

        // R9 stalled read meets completion
        wr(A_CTRL, 32'h1);
        wr(A_NUMER, 32'd1000);
        wr(A_DENOM, 32'd10);
        rd(A_RESULT, v, e, s);
        chk("R9 stall cycles", s, 32'd32);
        chk("R9 result", v, 32'd100);

        // R10 writes while busy, including on the completing edge
        wr(A_NUMER, 32'd2000);
        wr(A_DENOM, 32'd10);
        bus_addr = A_CTRL; bus_wdata = 32'h2; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (30) @(negedge clk);
        bus_addr = A_NUMER; bus_wdata = 32'h55; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rdv(A_NUMER, v);  chk("R10 last edge ignored", v, 32'd2000);
        rdv(A_CTRL, v);   chk("R10 ctrl ignored", v, 32'h201);
        rdv(A_RESULT, v); chk("R10 result", v, 32'd200);
        wr(A_NUMER, 32'h55);
        rdv(A_NUMER, v);  chk("R10 idle accepted", v, 32'h55);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule